// File: doc/BRIEF.md
# CAN Controller Host Register and Interrupt Unit

This block is the host-facing byte register file of a CAN controller. A host drives a plain address, write-data, write-strobe and read-strobe bus and gets back registered read data one cycle after each read. Through it the host sets the controller's mode, issues commands, reads status, services interrupts and fills the outgoing frame buffer. The protocol engine and the receive FIFO sit beside the block. They see single-cycle command strobes and a registered port into the transmit buffer. In return they report transmit completion, stored messages, overrun and the pending-message level.

A 13-byte window at addresses 16 to 28 is routed according to the reset-mode bit of the mode register. While the controller is held in reset mode, the first eight bytes of the window reach the acceptance code and mask bytes used by the receive filter. In operating mode, writes to the window fill the transmit buffer and reads return bytes of the current receive message. The interrupt register clears when it is read. The receive flag is loaded again at once if messages remain buffered, so a pending receive cannot be lost by a read. The interrupt line is a registered level.

Top module: `canctl_regs`

## Requirements
- R1: After synchronous reset the mode register (address 0) reads 0x01, the status register (address 2) reads 0x3C with `rx_pending_i` low, the interrupt register (address 3) reads 0x00, and `irq_o` is low.
- R2: A write to address 1 gives, in the cycle after it, a one-cycle pulse on `tx_req_o` for data bit 0, on `rx_release_o` for bit 2 and on `ovr_clear_o` for bit 3; a read of address 1 returns 0x00.
- R3: A transmit command clears status bits 3 (done) and 2 (buffer free); a `tx_done_i` pulse sets status bits 3 and 2, clears status bit 5 (transmitting) and sets interrupt bit 1.
- R4: An `rx_overrun_i` pulse sets status bit 1 and interrupt bit 3; a write of address 1 with bit 3 set clears both.
- R5: `irq_o` equals the OR of the bitwise AND of the interrupt enable register (address 4, read/write) and the interrupt register, and it changes at the same clock edge as those registers.
- R6: A read of address 3 returns the interrupt register and then clears it, except that bit 0 is loaded from `rx_pending_i`; an event arriving in the same cycle as the read is kept.
- R7: An `rx_stored_i` pulse sets interrupt bit 0, and status bit 0 always shows `rx_pending_i`.
- R8: A write to address 0 stores data bits 4:0 in the mode register; reads return them with bits 7:5 zero; mode bit 0 high means reset mode, and writing it low enters operating mode.
- R9: In reset mode, addresses 16 to 23 read and write acceptance bytes 0 to 7 (byte k at bit 8k of `acc_bytes_o`); addresses 24 to 28 read 0x00 and ignore writes.
- R10: In operating mode, a write to address 16+k stores transmit byte k, which `tx_rd_data_o` shows one cycle after `tx_rd_idx_i` is k; a read of address 16+k puts k on `rx_win_idx_o` and returns `rx_win_data_i`; the acceptance bytes do not change.
- R11: Any write to address 16 sets status bit 5.
- R12: Reads of addresses 5 to 15 return 0x00 and reads of addresses 29 to 31 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| mode_o | output | 5 | Current mode register |
| acc_bytes_o | output | 8*ACC_BYTES | Acceptance code and mask bytes, byte k at bit 8k |
| tx_req_o | output | 1 | Transmit request strobe |
| rx_release_o | output | 1 | Release receive buffer strobe |
| ovr_clear_o | output | 1 | Clear overrun strobe |
| tx_done_i | input | 1 | Transmission complete pulse from the engine |
| rx_overrun_i | input | 1 | Receive overrun pulse from the FIFO |
| rx_stored_i | input | 1 | Message stored pulse from the FIFO |
| rx_pending_i | input | 1 | High while the FIFO holds at least one message |
| rx_win_idx_o | output | IDX_W | Byte offset of the receive window read in progress |
| rx_win_data_i | input | 8 | Receive window byte at `rx_win_idx_o` |
| tx_rd_idx_i | input | IDX_W | Engine read index into the transmit buffer |
| tx_rd_data_o | output | 8 | Transmit buffer byte, one cycle after the index |
| irq_o | output | 1 | Level interrupt request |

## Verification
Register writes, command decodes and input event pulses all take effect at the clock edge that samples them. The status, interrupt and mode registers, the command strobes and `irq_o` therefore hold their new values one cycle after the stimulus. A read returns data one cycle after its strobe, as does a transmit buffer lookup after its index changes. The bench drives every input on the falling edge, holds it across exactly one rising edge and samples at the next falling edge. Each expected value is therefore compared in the first cycle it is due. Strobes are checked again one cycle later to confirm they have dropped.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  // Register byte addresses; the host software map depends on these.
  localparam int unsigned A_MODE    = 0;
  localparam int unsigned A_CMD     = 1;
  localparam int unsigned A_STAT    = 2;
  localparam int unsigned A_INT     = 3;
  localparam int unsigned A_IEN     = 4;
  localparam int unsigned A_RSVD_LO = 5;
  localparam int unsigned A_WIN     = 16;

  // Command bits
  localparam int CMD_TX  = 0;
  localparam int CMD_REL = 2;
  localparam int CMD_OVR = 3;

  // Status bits (bit 0 is the live pending level)
  localparam int ST_OVR  = 1;
  localparam int ST_FREE = 2;
  localparam int ST_DONE = 3;
  localparam int ST_BUSY = 5;

  // Interrupt bits
  localparam int IR_RX  = 0;
  localparam int IR_TX  = 1;
  localparam int IR_OVR = 3;

  localparam logic [4:0] MODE_RST_VAL = 5'h01;
  localparam logic [5:1] ST_RST_VAL   = 5'b11110;

  typedef enum logic [2:0] {
    RG_MODE, RG_CMD, RG_STAT, RG_INT, RG_IEN, RG_RSVD, RG_WIN, RG_NONE
  } region_e;
endpackage

// File: rtl/canctl_addr_dec.sv
module canctl_addr_dec
  import canctl_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BYTES = 13,
  parameter int ACC_BYTES = 8,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output region_e           region_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic              acc_hit_o
);
  logic [31:0] a;

  always_comb begin
    a         = 32'(bus_addr);
    win_idx_o = IDX_W'(a - A_WIN);
    acc_hit_o = (a >= A_WIN) && (a < A_WIN + ACC_BYTES);
    if (a == A_MODE)                                 region_o = RG_MODE;
    else if (a == A_CMD)                             region_o = RG_CMD;
    else if (a == A_STAT)                            region_o = RG_STAT;
    else if (a == A_INT)                             region_o = RG_INT;
    else if (a == A_IEN)                             region_o = RG_IEN;
    else if (a >= A_RSVD_LO && a < A_WIN)            region_o = RG_RSVD;
    else if (a >= A_WIN && a < A_WIN + WIN_BYTES)    region_o = RG_WIN;
    else                                             region_o = RG_NONE;
  end
endmodule

// File: rtl/canctl_int_ctrl.sv
module canctl_int_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ien_we,
  input  logic [W-1:0] ien_wdata,
  input  logic         int_rd,
  input  logic         pend_i,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] ir_q,
  output logic [W-1:0] ier_q,
  output logic         irq_o
);
  logic [W-1:0] base, ir_d, ier_d;

  always_comb begin
    // A read clears the flags but reloads the receive flag from the level.
    base  = int_rd ? {{(W-1){1'b0}}, pend_i} : ir_q;
    ir_d  = (base & ~clr_i) | ev_i;
    ier_d = ien_we ? ien_wdata : ier_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= '0;
      ier_q <= '0;
      irq_o <= 1'b0;
    end else begin
      ir_q  <= ir_d;
      ier_q <= ier_d;
      irq_o <= |(ir_d & ier_d);
    end
  end
endmodule

// File: rtl/canctl_txbuf_ram.sv
module canctl_txbuf_ram #(
  parameter int DEPTH = 13,
  parameter int IDX_W = 4,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/canctl_regs.sv
module canctl_regs
  import canctl_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BYTES = 13,
  parameter int ACC_BYTES = 8,
  parameter int IDX_W     = $clog2(WIN_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [7:0]             bus_rdata,
  output logic [4:0]             mode_o,
  output logic [8*ACC_BYTES-1:0] acc_bytes_o,
  output logic                   tx_req_o,
  output logic                   rx_release_o,
  output logic                   ovr_clear_o,
  input  logic                   tx_done_i,
  input  logic                   rx_overrun_i,
  input  logic                   rx_stored_i,
  input  logic                   rx_pending_i,
  output logic [IDX_W-1:0]       rx_win_idx_o,
  input  logic [7:0]             rx_win_data_i,
  input  logic [IDX_W-1:0]       tx_rd_idx_i,
  output logic [7:0]             tx_rd_data_o,
  output logic                   irq_o
);
  localparam int W         = 8;
  localparam int ACC_IDX_W = $clog2(ACC_BYTES);

  region_e          region;
  logic [IDX_W-1:0] win_idx;
  logic             acc_hit;
  logic [4:0]       mode_q;
  logic [5:1]       st_q, st_d;
  logic [W-1:0]     acc_q [ACC_BYTES];
  logic [W-1:0]     ir_q, ier_q, ev, clr;
  logic             reset_mode, wr_cmd, cmd_tx, cmd_rel, cmd_ovr;
  logic             mode_we, ien_we, win_we, acc_we, txb_we, busy_set, int_rd;

  canctl_addr_dec #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .ACC_BYTES(ACC_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .bus_addr (bus_addr),
    .region_o (region),
    .win_idx_o(win_idx),
    .acc_hit_o(acc_hit)
  );

  assign reset_mode = mode_q[0];
  assign wr_cmd     = bus_wr && (region == RG_CMD);
  assign cmd_tx     = wr_cmd && bus_wdata[CMD_TX];
  assign cmd_rel    = wr_cmd && bus_wdata[CMD_REL];
  assign cmd_ovr    = wr_cmd && bus_wdata[CMD_OVR];
  assign mode_we    = bus_wr && (region == RG_MODE);
  assign ien_we     = bus_wr && (region == RG_IEN);
  assign win_we     = bus_wr && (region == RG_WIN);
  assign acc_we     = win_we && reset_mode && acc_hit;
  assign txb_we     = win_we && !reset_mode;
  assign busy_set   = win_we && (win_idx == '0);
  assign int_rd     = bus_rd && (region == RG_INT);

  assign rx_win_idx_o = win_idx;
  assign mode_o       = mode_q;

  // Mode register and command strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_RST_VAL;
      tx_req_o     <= 1'b0;
      rx_release_o <= 1'b0;
      ovr_clear_o  <= 1'b0;
    end else begin
      if (mode_we) mode_q <= bus_wdata[4:0];
      tx_req_o     <= cmd_tx;
      rx_release_o <= cmd_rel;
      ovr_clear_o  <= cmd_ovr;
    end
  end

  // Acceptance bytes, reachable only in reset mode
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ACC_BYTES; i++) acc_q[i] <= '0;
    end else if (acc_we) begin
      acc_q[win_idx[ACC_IDX_W-1:0]] <= bus_wdata;
    end
  end

  for (genvar g = 0; g < ACC_BYTES; g++) begin : g_acc
    assign acc_bytes_o[g*W +: W] = acc_q[g];
  end

  canctl_txbuf_ram #(.DEPTH(WIN_BYTES), .IDX_W(IDX_W), .W(W)) u_txbuf (
    .clk    (clk),
    .we     (txb_we),
    .waddr  (win_idx),
    .wdata  (bus_wdata),
    .raddr  (tx_rd_idx_i),
    .rdata_q(tx_rd_data_o)
  );

  // Status: clears first, then sets, so an arriving event wins.
  always_comb begin
    st_d = st_q;
    if (cmd_ovr) st_d[ST_OVR] = 1'b0;
    if (cmd_tx) begin
      st_d[ST_DONE] = 1'b0;
      st_d[ST_FREE] = 1'b0;
    end
    if (tx_done_i) begin
      st_d[ST_DONE] = 1'b1;
      st_d[ST_FREE] = 1'b1;
      st_d[ST_BUSY] = 1'b0;
    end
    if (rx_overrun_i) st_d[ST_OVR]  = 1'b1;
    if (busy_set)     st_d[ST_BUSY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RST_VAL;
    else     st_q <= st_d;
  end

  always_comb begin
    ev = '0;
    ev[IR_RX]  = rx_stored_i;
    ev[IR_TX]  = tx_done_i;
    ev[IR_OVR] = rx_overrun_i;
    clr = '0;
    clr[IR_OVR] = cmd_ovr;
  end

  canctl_int_ctrl #(.W(W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .ien_we   (ien_we),
    .ien_wdata(bus_wdata),
    .int_rd   (int_rd),
    .pend_i   (rx_pending_i),
    .ev_i     (ev),
    .clr_i    (clr),
    .ir_q     (ir_q),
    .ier_q    (ier_q),
    .irq_o    (irq_o)
  );

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (region)
        RG_MODE: bus_rdata <= {3'b000, mode_q};
        RG_CMD:  bus_rdata <= 8'h00;
        RG_STAT: bus_rdata <= {2'b00, st_q, rx_pending_i};
        RG_INT:  bus_rdata <= ir_q;
        RG_IEN:  bus_rdata <= ier_q;
        RG_RSVD: bus_rdata <= 8'h00;
        RG_WIN:  bus_rdata <= reset_mode
                              ? (acc_hit ? acc_q[win_idx[ACC_IDX_W-1:0]] : 8'h00)
                              : rx_win_data_i;
        default: bus_rdata <= 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/canctl_regs_chk.sv
module canctl_regs_chk
  import canctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [4:0]        mode_o,
  input logic              tx_req_o,
  input logic              rx_release_o,
  input logic              tx_done_i,
  input logic              rx_overrun_i,
  input logic              rx_stored_i,
  input logic              rx_pending_i,
  input logic              irq_o,
  input logic [7:0]        ir_q,
  input logic [7:0]        ier_q,
  input logic [5:1]        st_q
);
  logic wr_cmd, wr_win0;
  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign wr_win0 = bus_wr && (bus_addr == ADDR_W'(A_WIN));

  // R2: transmit strobe only after a transmit command
  p_tx_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> $past(wr_cmd && bus_wdata[CMD_TX]));

  // R2: release command gives a release strobe
  p_rel_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && bus_wdata[CMD_REL]) |=> rx_release_o);

  // R2: command address reads as zero
  p_cmd_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_CMD)) |=> (bus_rdata == 8'h00));

  // R3: completion updates status and interrupt
  p_txdone_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_done_i && !wr_win0) |=>
      (st_q[ST_DONE] && st_q[ST_FREE] && !st_q[ST_BUSY] && ir_q[IR_TX]));

  // R4: overrun sets both flags
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (rst)
    rx_overrun_i |=> (st_q[ST_OVR] && ir_q[IR_OVR]));

  // R4: clear-overrun command clears both flags
  p_ovr_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && bus_wdata[CMD_OVR] && !rx_overrun_i) |=> (!st_q[ST_OVR] && !ir_q[IR_OVR]));

  // R5: interrupt line follows enabled flags
  p_irq_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(ier_q & ir_q));

  // R6: read-clear keeps only the pending receive flag
  p_ir_read_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_INT) && !tx_done_i && !rx_overrun_i && !rx_stored_i)
      |=> (ir_q == {7'b0, $past(rx_pending_i)}));

  // R8: mode register keeps the low five bits
  p_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_MODE)) |=> (mode_o == $past(bus_wdata[4:0])));

  // R11: window byte 0 write sets transmitting
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    wr_win0 |=> st_q[ST_BUSY]);
endmodule

bind canctl_regs canctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_canctl_regs.sv
module test_canctl_regs;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [4:0]  mode_o;
  logic [63:0] acc_bytes_o;
  logic        tx_req_o, rx_release_o, ovr_clear_o;
  logic        tx_done_i = 1'b0, rx_overrun_i = 1'b0, rx_stored_i = 1'b0, rx_pending_i = 1'b0;
  logic [IDX_W-1:0] rx_win_idx_o;
  logic [7:0]  rx_win_data_i;
  logic [IDX_W-1:0] tx_rd_idx_i = '0;
  logic [7:0]  tx_rd_data_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_st, m_ir, m_ier;

  always #10 clk = ~clk;

  // The FIFO side answers window reads with a pattern tied to the offset.
  assign rx_win_data_i = {4'hA, rx_win_idx_o};

  canctl_regs i_canctl_regs (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_ir & m_ier);
  endfunction

  function automatic logic [7:0] exp_stat();
    return {m_st[7:1], rx_pending_i};
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_addr = 5'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq_o, 1'b0);
    rd(0, d);  chk("R1 mode", d, 8'h01);
    rd(2, d);  chk("R1 status", d, 8'h3C);
    rd(3, d);  chk("R1 int", d, 8'h00);

    // R2 command address reads zero
    rd(1, d);  chk("R2 cmd read", d, 8'h00);

    // R9 acceptance bytes in reset mode
    for (int k = 0; k < 8; k++) wr(16 + k, 8'(8'h30 + k * 7));
    for (int k = 0; k < 8; k++) begin
      rd(16 + k, d); chk("R9 acc readback", d, 8'(8'h30 + k * 7));
    end
    chk("R9 acc out byte5", acc_bytes_o[47:40], 8'(8'h30 + 35));
    wr(24, 8'h55); rd(24, d); chk("R9 addr24 reads zero", d, 8'h00);
    wr(28, 8'h66); rd(28, d); chk("R9 addr28 reads zero", d, 8'h00);

    // R12 reserved and unmapped reads
    for (int a = 5; a < 16; a++) begin
      rd(a, d); chk("R12 reserved zero", d, 8'h00);
    end
    for (int a = 29; a < 32; a++) begin
      rd(a, d); chk("R12 unmapped FF", d, 8'hFF);
    end

    // R8 mode write keeps low five bits, enters operating mode
    wr(0, 8'hE8); rd(0, d); chk("R8 mode masked", d, 8'h08);
    chk("R8 mode port", mode_o, 5'h08);

    // R3/R11 transmitting bit: clear with a completion, set with byte 0 write
    tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
    rd(2, d); chk("R3 done clears busy", d[5], 1'b0);
    chk("R3 done sets 3:2", d[3:2], 2'b11);
    rd(3, d); chk("R3 int bit1", d, 8'h02);
    wr(17, 8'h11); rd(2, d); chk("R11 addr17 no busy", d[5], 1'b0);
    wr(16, 8'h8C); rd(2, d); chk("R11 addr16 sets busy", d[5], 1'b1);

    // R10 transmit buffer and receive window in operating mode
    for (int k = 1; k < 13; k++) wr(16 + k, 8'(8'hC0 + k));
    for (int k = 0; k < 13; k++) begin
      tx_rd_idx_i = 4'(k);
      @(negedge clk);
      chk("R10 tx buffer", tx_rd_data_o, (k == 0) ? 8'h8C : 8'(8'hC0 + k));
    end
    chk("R10 acc unchanged", acc_bytes_o[7:0], 8'h30);
    rd(20, d); chk("R10 rx window", d, 8'hA4);
    rd(28, d); chk("R10 rx window last", d, 8'hAC);

    // R2/R3 transmit command strobe and status clear
    wr(1, 8'h01);
    chk("R2 tx strobe", tx_req_o, 1'b1);
    chk("R2 no release", rx_release_o, 1'b0);
    idle(1);
    chk("R2 tx strobe drops", tx_req_o, 1'b0);
    rd(2, d); chk("R3 req clears 3:2", d[3:2], 2'b00);
    idle(3);
    tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
    rd(2, d); chk("R3 complete", d & 8'h2C, 8'h0C);

    // R6 read with pending messages and a same-cycle event
    rd(3, d);
    rx_pending_i = 1'b1;
    bus_addr = 5'd3; bus_rd = 1'b1; tx_done_i = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; tx_done_i = 1'b0;
    rd(3, d); chk("R6 event kept with reload", d, 8'h03);
    rd(3, d); chk("R6 reload from pending", d, 8'h01);
    rx_pending_i = 1'b0;
    rd(3, d); rd(3, d); chk("R6 cleared", d, 8'h00);

    // Random phase against the model
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_st = 8'h3C; m_ir = 8'h00; m_ier = 8'h00;
    wr(0, 8'h00);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: begin
          tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
          m_st = (m_st | 8'h0C) & ~8'h20; m_ir |= 8'h02;
        end
        1: begin
          rx_stored_i = 1'b1; @(negedge clk); rx_stored_i = 1'b0;
          m_ir |= 8'h01;
        end
        2: begin
          rx_overrun_i = 1'b1; @(negedge clk); rx_overrun_i = 1'b0;
          m_st |= 8'h02; m_ir |= 8'h08;
        end
        3: begin
          rx_pending_i = 1'($urandom_range(0, 1)); @(negedge clk);
        end
        4: begin
          logic [7:0] v;
          v = 8'($urandom);
          wr(4, v); m_ier = v;
          rd(4, d); chk("R5 enable readback", d, m_ier);
        end
        5: begin
          rd(3, d); chk("R6 int read", d, m_ir);
          m_ir = {7'b0, rx_pending_i};
        end
        6: begin
          rd(2, d); chk("R7 status", d, exp_stat());
        end
        default: begin
          logic [7:0] c;
          c = 8'($urandom) & 8'h0D;
          wr(1, c);
          chk("R2 tx strobe", tx_req_o, c[0]);
          chk("R2 release strobe", rx_release_o, c[2]);
          chk("R4 clear strobe", ovr_clear_o, c[3]);
          if (c[0]) m_st &= ~8'h0C;
          if (c[3]) begin m_st &= ~8'h02; m_ir &= ~8'h08; end
        end
      endcase
      chk("R5 irq", irq_o, exp_irq());
    end

    done = 1'b1;
    report();
  end
endmodule